// File: doc/BRIEF.md
# Parallel Bus Region Timing Sequencer

This block drives the strobes of one memory-mapped region on an asynchronous parallel bus, for example a removable flash card in programmed I/O mode. A request port starts a single read or write. The sequencer then places the address on the bus and moves through a fixed chain of phases: address setup, chip-enable lead-in, the read or write strobe, an optional ready-stretched extension, hold, and a recovery pause. When the chain is done it acknowledges the request and returns the sampled read data.

Each phase length comes from its own configuration field. The field is counted in units of a multiplied base clock, and the multiplier can be 2 or 4. When wait mode is on, the device's ready line can lengthen the strobe. A watchdog on that wait ends the access with an error if the device never becomes ready. A region whose enable input is low ignores every request.

Top module: `pbus_region_seq`

## Requirements
- R1: While reset is held and after it is released, `bus_ce_n`, `bus_oe_n` and `bus_we_n` are high, and `ack` and `rsp_err` are low.
- R2: A phase whose field holds N lasts (N+1)*M clock cycles. M is 2 when `cfg_mult4`=0 and 4 when `cfg_mult4`=1. A field of 0 therefore still lasts M cycles.
- R3: A request is accepted at a clock edge where the block is idle, `cfg_en`=1 and `req`=1. `bus_addr` takes `req_addr` at that edge and stays stable until the next accepted request. `bus_ce_n` falls (`cfg_addr_setup`+1)*M cycles after the accept edge. The strobe falls (`cfg_ce_delay`+1)*M cycles after that.
- R4: A read (`req_wr`=0) pulses only `bus_oe_n`, for (`cfg_rd_width`+1)*M cycles. A write (`req_wr`=1) pulses only `bus_we_n`, for (`cfg_wr_width`+1)*M cycles. During a write strobe, `bus_dout` equals `req_wdata` and `bus_dout_en`=1.
- R5: After the strobe rises, `bus_ce_n` stays low for (`cfg_rd_hold`+1)*M cycles on reads, or (`cfg_wr_hold`+1)*M cycles on writes. `ack` then rises (`cfg_pause`+1)*M cycles after `bus_ce_n` rises.
- R6: On a read, `rsp_rdata` holds the value that `bus_din` had at the clock edge where `bus_oe_n` returns high. Values driven earlier in the strobe, or after it ends, are not returned.
- R7: With `cfg_wait_en`=1, a strobe whose programmed width has expired stays asserted until `bus_iordy` is sampled high, then for a further (`cfg_wait_hold`+1)*M cycles. If `bus_iordy` is already high when the width expires, only the further hold is added. With `cfg_wait_en`=0, `bus_iordy` has no effect on any timing.
- R8: If `bus_iordy` stays low for TMO_UNITS*M cycles (1024*M by default) after the programmed width expires, the strobe ends and the access finishes with `rsp_err`=1 at `ack`. The next accepted request clears `rsp_err`.
- R9: While `cfg_en`=0, a request produces no chip-enable, no strobe and no `ack`.
- R10: `ack` is high for exactly one cycle per access. The block returns to idle only after `ack` and accepts no new request before then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Region enable |
| cfg_mult4 | input | 1 | Unit multiplier select: 0 gives 2 clocks, 1 gives 4 clocks |
| cfg_addr_setup | input | CW | Address valid before chip-enable |
| cfg_ce_delay | input | CW | Chip-enable to strobe delay |
| cfg_rd_width | input | CW | Read strobe width |
| cfg_wr_width | input | CW | Write strobe width |
| cfg_rd_hold | input | CW | Chip-enable hold after a read strobe |
| cfg_wr_hold | input | CW | Chip-enable hold after a write strobe |
| cfg_pause | input | CW | Recovery before acknowledge |
| cfg_wait_en | input | 1 | Ready-line stretching enable |
| cfg_wait_hold | input | CW | Strobe extension after ready is seen |
| req | input | 1 | Access request, held until ack |
| req_wr | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Sampled read data |
| rsp_err | output | 1 | Ready-wait timeout flag for the last access |
| bus_addr | output | AW | Bus address |
| bus_dout | output | DW | Bus write data |
| bus_dout_en | output | 1 | Bus data output enable |
| bus_din | input | DW | Bus read data |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output (read) strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_iordy | input | 1 | Device ready |

## Verification
The assertions take three things for granted. The configuration inputs hold still for the whole of an access. `bus_iordy` is already synchronous to `clk` when the synchroniser option is off. `req` with its address, data and direction is held until `ack`. The stimulus rewrites configuration only between accesses, while the block is idle. It drives `req`, `bus_din` and `bus_iordy` only at falling clock edges, and it drops `req` in the same half-cycle that it sees `ack`. The strobe-width assertion also relies on the smaller multiplier being at least 2, which is checked at elaboration.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_ADDR,
      S_CESU,
      S_STRB,
      S_WAIT,
      S_WHOLD,
      S_HOLD,
      S_PAUSE,
      S_DONE
   } pbus_state_t;

   function automatic logic ce_phase(pbus_state_t s);
      return (s == S_CESU) || (s == S_STRB) || (s == S_WAIT) ||
             (s == S_WHOLD) || (s == S_HOLD);
   endfunction

   function automatic logic strobe_phase(pbus_state_t s);
      return (s == S_STRB) || (s == S_WAIT) || (s == S_WHOLD);
   endfunction

endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
   parameter int UW      = 10,
   parameter int MW      = 2,
   parameter int MULT_LO = 2,
   parameter int MULT_HI = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          mult_hi,
   input  logic [UW-1:0] limit,
   output logic          phase_end
);

   logic [MW-1:0] mcnt;
   logic [UW-1:0] ucnt;
   logic [MW-1:0] m_last;
   logic          unit_end;

   assign m_last    = mult_hi ? MW'(MULT_HI - 1) : MW'(MULT_LO - 1);
   assign unit_end  = (mcnt == m_last);
   assign phase_end = unit_end && (ucnt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         mcnt <= '0;
         ucnt <= '0;
      end else if (unit_end) begin
         mcnt <= '0;
         ucnt <= ucnt + 1'b1;
      end else begin
         mcnt <= mcnt + 1'b1;
      end
   end

endmodule

// File: rtl/pbus_limit_sel.sv
module pbus_limit_sel
   import pbus_pkg::*;
#(
   parameter int CW        = 6,
   parameter int UW        = 10,
   parameter int TMO_UNITS = 1024
) (
   input  pbus_state_t   st,
   input  logic          is_wr,
   input  logic [CW-1:0] cfg_addr_setup,
   input  logic [CW-1:0] cfg_ce_delay,
   input  logic [CW-1:0] cfg_rd_width,
   input  logic [CW-1:0] cfg_wr_width,
   input  logic [CW-1:0] cfg_rd_hold,
   input  logic [CW-1:0] cfg_wr_hold,
   input  logic [CW-1:0] cfg_pause,
   input  logic [CW-1:0] cfg_wait_hold,
   output logic [UW-1:0] limit
);

   localparam logic [UW-1:0] TMO_LAST = UW'(TMO_UNITS - 1);

   always_comb begin
      unique case (st)
         S_ADDR:  limit = UW'(cfg_addr_setup);
         S_CESU:  limit = UW'(cfg_ce_delay);
         S_STRB:  limit = is_wr ? UW'(cfg_wr_width) : UW'(cfg_rd_width);
         S_WAIT:  limit = TMO_LAST;
         S_WHOLD: limit = UW'(cfg_wait_hold);
         S_HOLD:  limit = is_wr ? UW'(cfg_wr_hold) : UW'(cfg_rd_hold);
         S_PAUSE: limit = UW'(cfg_pause);
         default: limit = '0;
      endcase
   end

endmodule

// File: rtl/pbus_region_seq.sv
module pbus_region_seq
   import pbus_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 16,
   parameter int CW         = 6,
   parameter int MULT_LO    = 2,
   parameter int MULT_HI    = 4,
   parameter int TMO_UNITS  = 1024,
   parameter bit IORDY_SYNC = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_en,
   input  logic          cfg_mult4,
   input  logic [CW-1:0] cfg_addr_setup,
   input  logic [CW-1:0] cfg_ce_delay,
   input  logic [CW-1:0] cfg_rd_width,
   input  logic [CW-1:0] cfg_wr_width,
   input  logic [CW-1:0] cfg_rd_hold,
   input  logic [CW-1:0] cfg_wr_hold,
   input  logic [CW-1:0] cfg_pause,
   input  logic          cfg_wait_en,
   input  logic [CW-1:0] cfg_wait_hold,
   input  logic          req,
   input  logic          req_wr,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          ack,
   output logic [DW-1:0] rsp_rdata,
   output logic          rsp_err,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_dout,
   output logic          bus_dout_en,
   input  logic [DW-1:0] bus_din,
   output logic          bus_ce_n,
   output logic          bus_oe_n,
   output logic          bus_we_n,
   input  logic          bus_iordy
);

   localparam int CNT_SPAN = ((1 << CW) > TMO_UNITS) ? (1 << CW) : TMO_UNITS;
   localparam int UW       = $clog2(CNT_SPAN);
   localparam int MW       = (MULT_HI > 1) ? $clog2(MULT_HI) : 1;

   if (MULT_LO < 2) begin : g_bad_mult_lo
      $error("MULT_LO must be at least 2");
   end
   if (MULT_HI < MULT_LO) begin : g_bad_mult_hi
      $error("MULT_HI must not be below MULT_LO");
   end
   if (TMO_UNITS < 2) begin : g_bad_tmo
      $error("TMO_UNITS must be at least 2");
   end
   if (CW < 1 || AW < 1 || DW < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   pbus_state_t   st, st_nxt;
   logic          is_wr;
   logic          iordy_s;
   logic          phase_end;
   logic          restart;
   logic          timeout;
   logic [UW-1:0] limit;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] rdata_q;
   logic          err_q;

   if (IORDY_SYNC) begin : g_iordy_sync
      logic [1:0] sync_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[0], bus_iordy};
      end
      assign iordy_s = sync_q[1];
   end else begin : g_iordy_direct
      assign iordy_s = bus_iordy;
   end

   pbus_limit_sel #(
      .CW        (CW),
      .UW        (UW),
      .TMO_UNITS (TMO_UNITS)
   ) u_limit (
      .st             (st),
      .is_wr          (is_wr),
      .cfg_addr_setup (cfg_addr_setup),
      .cfg_ce_delay   (cfg_ce_delay),
      .cfg_rd_width   (cfg_rd_width),
      .cfg_wr_width   (cfg_wr_width),
      .cfg_rd_hold    (cfg_rd_hold),
      .cfg_wr_hold    (cfg_wr_hold),
      .cfg_pause      (cfg_pause),
      .cfg_wait_hold  (cfg_wait_hold),
      .limit          (limit)
   );

   assign restart = (st_nxt != st);

   pbus_phase_timer #(
      .UW      (UW),
      .MW      (MW),
      .MULT_LO (MULT_LO),
      .MULT_HI (MULT_HI)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .mult_hi   (cfg_mult4),
      .limit     (limit),
      .phase_end (phase_end)
   );

   always_comb begin
      st_nxt  = st;
      timeout = 1'b0;
      unique case (st)
         S_IDLE:  if (req && cfg_en) st_nxt = S_ADDR;
         S_ADDR:  if (phase_end) st_nxt = S_CESU;
         S_CESU:  if (phase_end) st_nxt = S_STRB;
         S_STRB: begin
            if (phase_end) begin
               if (!cfg_wait_en) st_nxt = S_HOLD;
               else if (iordy_s) st_nxt = S_WHOLD;
               else              st_nxt = S_WAIT;
            end
         end
         S_WAIT: begin
            if (iordy_s) begin
               st_nxt = S_WHOLD;
            end else if (phase_end) begin
               st_nxt  = S_HOLD;
               timeout = 1'b1;
            end
         end
         S_WHOLD: if (phase_end) st_nxt = S_HOLD;
         S_HOLD:  if (phase_end) st_nxt = S_PAUSE;
         S_PAUSE: if (phase_end) st_nxt = S_DONE;
         S_DONE:  st_nxt = S_IDLE;
         default: st_nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         is_wr       <= 1'b0;
         addr_q      <= '0;
         wdata_q     <= '0;
         rdata_q     <= '0;
         err_q       <= 1'b0;
         ack         <= 1'b0;
         bus_ce_n    <= 1'b1;
         bus_oe_n    <= 1'b1;
         bus_we_n    <= 1'b1;
         bus_dout_en <= 1'b0;
      end else begin
         st <= st_nxt;
         if (st == S_IDLE && st_nxt == S_ADDR) begin
            is_wr   <= req_wr;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            err_q   <= 1'b0;
         end
         if (timeout) err_q <= 1'b1;
         if (!is_wr && strobe_phase(st) && !strobe_phase(st_nxt))
            rdata_q <= bus_din;
         ack         <= (st_nxt == S_DONE);
         bus_ce_n    <= !ce_phase(st_nxt);
         bus_oe_n    <= !(strobe_phase(st_nxt) && !is_wr);
         bus_we_n    <= !(strobe_phase(st_nxt) && is_wr);
         bus_dout_en <= ce_phase(st_nxt) && is_wr;
      end
   end

   assign bus_addr  = addr_q;
   assign bus_dout  = wdata_q;
   assign rsp_rdata = rdata_q;
   assign rsp_err   = err_q;

endmodule

// File: rtl/pbus_region_chk.sv
module pbus_region_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ack,
   input logic [AW-1:0] bus_addr,
   input logic          bus_dout_en,
   input logic          bus_ce_n,
   input logic          bus_oe_n,
   input logic          bus_we_n
);

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_oe_n && !bus_we_n)); // R4

   AST_STROBE_INSIDE_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_oe_n || !bus_we_n) |-> !bus_ce_n); // R3

   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ce_n && !$fell(bus_ce_n)) |-> $stable(bus_addr)); // R3

   AST_WR_DATA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we_n |-> bus_dout_en); // R4

   AST_RD_STROBE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_oe_n) |-> !$past(bus_oe_n, 2)); // R2

   AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R10

   AST_ACK_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> bus_ce_n); // R5

endmodule

bind pbus_region_seq pbus_region_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ack         (ack),
   .bus_addr    (bus_addr),
   .bus_dout_en (bus_dout_en),
   .bus_ce_n    (bus_ce_n),
   .bus_oe_n    (bus_oe_n),
   .bus_we_n    (bus_we_n)
);

// File: tb/tb_pbus_region_seq.sv
module tb_pbus_region_seq;

   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 6;
   localparam int TMO = 1024;
   localparam int NEVER = 100000;

   typedef struct {
      int          t_req;
      int          d_setup;
      int          d_ce2st;
      int          d_strb;
      int          d_hold;
      int          d_pause;
      bit          wr;
      logic [15:0] wdata;
      logic [15:0] rdata;
      bit          err;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_en = 1'b1, cfg_mult4 = 1'b0, cfg_wait_en = 1'b0;
   logic [CW-1:0] c_adr = '0, c_ce = '0, c_rw = '0, c_ww = '0;
   logic [CW-1:0] c_rh = '0, c_wh = '0, c_ps = '0, c_wt = '0;
   logic          req = 1'b0, req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          ack, rsp_err, bus_dout_en, bus_ce_n, bus_oe_n, bus_we_n;
   logic [DW-1:0] rsp_rdata, bus_dout;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_din = '0;
   logic          bus_iordy = 1'b0;

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;
   exp_t q[$];

   logic [DW-1:0] dev_late = '0;
   int            dev_rdy_at = 0;

   pbus_region_seq #(.AW(AW), .DW(DW), .CW(CW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mult4(cfg_mult4),
      .cfg_addr_setup(c_adr), .cfg_ce_delay(c_ce), .cfg_rd_width(c_rw),
      .cfg_wr_width(c_ww), .cfg_rd_hold(c_rh), .cfg_wr_hold(c_wh),
      .cfg_pause(c_ps), .cfg_wait_en(cfg_wait_en), .cfg_wait_hold(c_wt),
      .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
      .ack(ack), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
      .bus_din(bus_din), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
      .bus_we_n(bus_we_n), .bus_iordy(bus_iordy)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string rq, input bit ok, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   // device model: read data changes during the strobe, ready after a delay
   int dcnt = 0;
   always @(negedge clk) begin
      if (!bus_oe_n || !bus_we_n) begin
         dcnt = dcnt + 1;
         bus_din = (dcnt >= 2) ? dev_late : ~dev_late;
      end else begin
         dcnt = 0;
         bus_din = 16'h0F0F;
      end
      bus_iordy = (dev_rdy_at == 0) || (dcnt != 0 && dcnt >= dev_rdy_at);
   end

   // monitor / scoreboard
   logic p_ce = 1'b1, p_st = 1'b0, p_ack = 1'b0;
   int   t_ce, t_cer, t_st, t_ste;
   bit   wrong;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic st_lo;
         st_lo = !bus_oe_n || !bus_we_n;
         if (p_ce && !bus_ce_n) t_ce = cyc;
         if (!p_ce && bus_ce_n) t_cer = cyc;
         if (!p_st && st_lo) begin
            t_st = cyc;
            if (q.size() > 0 && q[0].wr) begin
               chk("R4 write data", bus_dout == q[0].wdata, bus_dout, q[0].wdata);
               chk("R4 dout enable", bus_dout_en, bus_dout_en, 1);
            end
         end
         if (p_st && !st_lo) t_ste = cyc;
         if (q.size() > 0 && st_lo && ((q[0].wr && !bus_oe_n) || (!q[0].wr && !bus_we_n)))
            wrong = 1;
         if (p_ack) chk("R10 ack one cycle", !ack, ack, 0);
         if (ack) begin
            if (q.size() == 0) begin
               chk("R10 unexpected ack", 0, 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk("R3 address setup", (t_ce - e.t_req) == e.d_setup, t_ce - e.t_req, e.d_setup);
               chk("R3 ce to strobe", (t_st - t_ce) == e.d_ce2st, t_st - t_ce, e.d_ce2st);
               chk("R4 R7 R8 strobe width", (t_ste - t_st) == e.d_strb, t_ste - t_st, e.d_strb);
               chk("R5 hold", (t_cer - t_ste) == e.d_hold, t_cer - t_ste, e.d_hold);
               chk("R5 pause", (cyc - t_cer) == e.d_pause, cyc - t_cer, e.d_pause);
               chk("R4 wrong strobe", !wrong, wrong, 0);
               chk("R8 err flag", rsp_err == e.err, rsp_err, e.err);
               if (!e.wr) chk("R6 read data", rsp_rdata == e.rdata, rsp_rdata, e.rdata);
            end
            wrong = 0;
         end
         p_ce = bus_ce_n; p_st = st_lo; p_ack = ack;
      end
   end

   task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d, input int rdy);
      exp_t e;
      int m, base;
      m = cfg_mult4 ? 4 : 2;
      base = ((wr ? int'(c_ww) : int'(c_rw)) + 1) * m;
      e.wr = wr; e.wdata = d; e.rdata = d; e.err = 0;
      e.d_setup = (int'(c_adr) + 1) * m;
      e.d_ce2st = (int'(c_ce) + 1) * m;
      if (!cfg_wait_en) e.d_strb = base;
      else if (rdy >= NEVER) begin e.d_strb = base + TMO * m; e.err = 1; end
      else e.d_strb = ((rdy > base) ? rdy : base) + (int'(c_wt) + 1) * m;
      e.d_hold = ((wr ? int'(c_wh) : int'(c_rh)) + 1) * m;
      e.d_pause = (int'(c_ps) + 1) * m;
      @(negedge clk);
      dev_late = d; dev_rdy_at = rdy;
      e.t_req = cyc + 1;
      q.push_back(e);
      req = 1; req_wr = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      while (!ack) @(negedge clk);
      req = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic set_cfg(input bit m4, input int adr, input int ce, input int rw, input int ww,
                          input int rh, input int wh, input int ps, input bit wen, input int wt);
      cfg_mult4 = m4; c_adr = CW'(adr); c_ce = CW'(ce); c_rw = CW'(rw); c_ww = CW'(ww);
      c_rh = CW'(rh); c_wh = CW'(wh); c_ps = CW'(ps); cfg_wait_en = wen; c_wt = CW'(wt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset ce_n", bus_ce_n, bus_ce_n, 1);
      rst_n = 1;
      @(negedge clk);
      chk("R1 idle strobes", bus_oe_n && bus_we_n, {bus_oe_n, bus_we_n}, 3);
      chk("R1 idle ack/err", !ack && !rsp_err, {ack, rsp_err}, 0);
      // R2 R3 R4 R6: read with 2x multiplier, ready ignored when wait mode off (R7)
      set_cfg(0, 1, 2, 3, 0, 1, 0, 2, 0, 0);
      access(0, 16'h1234, 16'hA55A, NEVER);
      // write with 4x multiplier
      set_cfg(1, 0, 1, 0, 2, 0, 3, 0, 0, 0);
      access(1, 16'h00FE, 16'hC3D2, NEVER);
      // R2 boundary: all counts zero, both multipliers
      set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      access(0, 16'h0001, 16'h7E81, NEVER);
      set_cfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      access(1, 16'hFFFF, 16'h0001, NEVER);
      // R7: ready already high, then late ready on read and write
      set_cfg(0, 0, 1, 1, 1, 0, 0, 0, 1, 2);
      access(0, 16'h0100, 16'h5AA5, 0);
      access(0, 16'h0101, 16'h1111, 15);
      set_cfg(1, 1, 0, 0, 0, 1, 1, 1, 1, 0);
      access(1, 16'h0202, 16'h2222, 20);
      // R8: ready never arrives, then error cleared by next access
      set_cfg(0, 0, 0, 2, 0, 0, 0, 0, 1, 1);
      access(0, 16'h0303, 16'h3333, NEVER);
      access(0, 16'h0304, 16'h4444, 3);
      // R9: disabled region ignores a held request
      begin
         bit seen = 0;
         @(negedge clk);
         cfg_en = 0; req = 1; req_wr = 0; req_addr = 16'hBEEF;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!bus_ce_n || !bus_oe_n || ack) seen = 1;
         end
         chk("R9 disabled region quiet", !seen, seen, 0);
         req = 0;
         @(negedge clk);
         cfg_en = 1;
      end
      chk("R10 scoreboard drained", q.size() == 0, q.size(), 0);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule